// File: doc/BRIEF.md
# Vector Control Word Sequencer

This block holds one control byte for every test vector and turns the byte of the vector being driven into sequencing actions. A host fills the control memory while the block is in load mode. In drive mode the vector address generator presents the current vector address and pulses a per-vector latch strobe. On that strobe the byte stored at the address moves into a control register. The bits of that register then tell the address generator to stop, hold for an external event, decrement the loop counter, or raise a capture strobe for the input section.

The loop counter lives outside this block. It reports through a single "exhausted" input, which the block uses to decide whether a loop-then-stop vector should stop. The external WAIT line passes through a two-stage synchronizer and an edge detector. The edge it looks for is programmable: rising or falling. In test mode every decoded action is masked. The raw memory word at the presented address is also brought out in test mode, so stored patterns can be stepped through, read back and folded into a checksum without anything looping or stopping.

Top module: `vctl_seq`

## Requirements
- R1: The control memory has 2^ADDR_W entries of 8 bits. A byte written in load mode is stored at `host_addr`. While `test_mode` is high, `raw_q` shows the stored byte at `vec_addr` combinationally. While `test_mode` is low, `raw_q` is 0.
- R2: A host write made while `load_mode` is low leaves the memory unchanged.
- R3: While `load_mode` is high, the control register and the wait state are cleared on every clock edge. `lat_stb` pulses have no effect. `halt_o`, `loop_dec_o`, `hold_o` and `cap_o` read 0 from the next edge on.
- R4: In drive mode (`load_mode` low), a `lat_stb` pulse captures the byte at `vec_addr` into the control register. The decoded outputs follow from the next clock edge. The bit meanings are: bit0 stop, bit1 wait, bit2 loop, bit3 loop-then-stop, bit4 capture.
- R5: `halt_o` is high when bit0 is set, or when bit3 is set and `loop_exhausted` is high.
- R6: `loop_dec_o` is high when bit2 or bit3 is set.
- R7: When `mid_stb` is high at a clock edge and bit4 is set, `cap_o` is high for the following cycle. When `mid_stb` is high and bit4 is clear, `cap_o` stays low.
- R8: Capturing a byte with bit1 set raises `hold_o` from the next edge. `wait_fall` selects the release edge: 0 means a rising edge of `wait_in`, 1 means a falling edge. `hold_o` drops on the third rising clock edge after the selected edge appears on `wait_in`. An edge of the other polarity does not release the hold.
- R9: A selected edge on `wait_in` that happens before the hold is entered does not release a later hold.
- R10: A `lat_stb` pulse while `hold_o` is high is ignored.
- R11: While `test_mode` is high, `halt_o`, `loop_dec_o` and `hold_o` are low and no hold is entered. A `mid_stb` pulse does not raise `cap_o`. The register keeps its captured byte, so the byte's actions appear once `test_mode` falls.
- R12: After a synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_mode | input | 1 | 1 = memory load, 0 = vector drive |
| test_mode | input | 1 | Masks all actions, exposes raw memory word |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | 8 | Host write byte |
| vec_addr | input | ADDR_W | Current vector address |
| lat_stb | input | 1 | Per-vector latch strobe |
| mid_stb | input | 1 | Mid-period pulse of the vector timebase |
| wait_in | input | 1 | Asynchronous external wait line |
| wait_fall | input | 1 | Edge select, 0 rising, 1 falling |
| loop_exhausted | input | 1 | Loop count exhausted, from external counter |
| halt_o | output | 1 | Stop vector driving |
| loop_dec_o | output | 1 | Decrement-and-test request to loop counter |
| hold_o | output | 1 | Suspend advancing to the next vector |
| cap_o | output | 1 | Capture strobe for the input section |
| raw_q | output | 8 | Raw memory word in test mode, else 0 |

## Verification
The memory is filled with an arithmetic pattern that spreads every bit combination across a 64-entry configuration. It is then swept twice. The test-mode sweep compares every address with the pattern. This separates storage and addressing faults from decode faults, because all actions must stay masked during this sweep. The drive sweep captures every address in turn. It alternates `loop_exhausted` with the address parity and the wait polarity with address bit 1, so the stop-on-exhausted path and both release edges are each exercised over many different bytes. Directed words then cover the remaining cases: an edge that arrives too early, an edge of the wrong polarity, a strobe while held, and load or test mode entered while a byte is active.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

    localparam int CTL_W = 8;

    // Bit order of the stored control byte, LSB last in this declaration.
    typedef struct packed {
        logic [2:0] spare;
        logic       cap;
        logic       lphalt;
        logic       loop;
        logic       wt;
        logic       halt;
    } ctl_word_t;

    typedef enum logic [0:0] {
        SEQ_RUN  = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic halt;
        logic loop_dec;
        logic hold;
    } ctl_act_t;

    function automatic ctl_act_t decode_word(
        input ctl_word_t w,
        input logic      exhausted,
        input logic      holding,
        input logic      mask
    );
        ctl_act_t a;
        a.halt     = ~mask & (w.halt | (w.lphalt & exhausted));
        a.loop_dec = ~mask & (w.loop | w.lphalt);
        a.hold     = ~mask & holding;
        return a;
    endfunction

    function automatic logic edge_hit(
        input logic prev,
        input logic cur,
        input logic fall
    );
        return fall ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/vctl_store.sv
module vctl_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/vctl_edge_sync.sv
module vctl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fall_sel,
    output logic edge_o
);
    import vctl_pkg::*;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[STAGES-1];
    end

    assign edge_o = edge_hit(prev_q, chain[STAGES-1], fall_sel);

endmodule

// File: rtl/vctl_word_reg.sv
module vctl_word_reg (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_mode,
    input  logic                        test_mode,
    input  logic                        lat_stb,
    input  logic                        mid_stb,
    input  logic [vctl_pkg::CTL_W-1:0]  word_in,
    input  logic                        edge_seen,
    input  logic                        exhausted,
    output logic                        halt_o,
    output logic                        loop_dec_o,
    output logic                        hold_o,
    output logic                        cap_o
);
    import vctl_pkg::*;

    ctl_word_t  word_q;
    ctl_word_t  word_d;
    seq_state_e state_q;
    logic       cap_q;
    ctl_act_t   act;

    assign word_d = ctl_word_t'(word_in);

    always_ff @(posedge clk) begin
        if (rst || load_mode) begin
            word_q  <= '0;
            state_q <= SEQ_RUN;
            cap_q   <= 1'b0;
        end else begin
            cap_q <= word_q.cap & mid_stb & ~test_mode;
            unique case (state_q)
                SEQ_RUN: begin
                    if (lat_stb) begin
                        word_q <= word_d;
                        if (word_d.wt && !test_mode) begin
                            state_q <= SEQ_HOLD;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (edge_seen) begin
                        state_q <= SEQ_RUN;
                    end
                end
                default: state_q <= SEQ_RUN;
            endcase
        end
    end

    assign act        = decode_word(word_q, exhausted, state_q == SEQ_HOLD, test_mode);
    assign halt_o     = act.halt;
    assign loop_dec_o = act.loop_dec;
    assign hold_o     = act.hold;
    assign cap_o      = cap_q;

endmodule

// File: rtl/vctl_seq.sv
module vctl_seq #(
    parameter int ADDR_W    = 10,
    parameter int SYNC_STGS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_mode,
    input  logic                       test_mode,
    input  logic                       host_we,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [vctl_pkg::CTL_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0]          vec_addr,
    input  logic                       lat_stb,
    input  logic                       mid_stb,
    input  logic                       wait_in,
    input  logic                       wait_fall,
    input  logic                       loop_exhausted,
    output logic                       halt_o,
    output logic                       loop_dec_o,
    output logic                       hold_o,
    output logic                       cap_o,
    output logic [vctl_pkg::CTL_W-1:0] raw_q
);
    import vctl_pkg::*;

    logic             wr_en;
    logic [CTL_W-1:0] rd_word;
    logic             wait_edge;

    assign wr_en = host_we & load_mode;

    vctl_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (CTL_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (vec_addr),
        .rdata (rd_word)
    );

    vctl_edge_sync #(
        .STAGES (SYNC_STGS)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (wait_in),
        .fall_sel (wait_fall),
        .edge_o   (wait_edge)
    );

    vctl_word_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .load_mode  (load_mode),
        .test_mode  (test_mode),
        .lat_stb    (lat_stb),
        .mid_stb    (mid_stb),
        .word_in    (rd_word),
        .edge_seen  (wait_edge),
        .exhausted  (loop_exhausted),
        .halt_o     (halt_o),
        .loop_dec_o (loop_dec_o),
        .hold_o     (hold_o),
        .cap_o      (cap_o)
    );

    assign raw_q = test_mode ? rd_word : '0;

endmodule

// File: rtl/vctl_seq_chk.sv
module vctl_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_mode,
    input logic       test_mode,
    input logic       lat_stb,
    input logic       mid_stb,
    input logic       halt_o,
    input logic       loop_dec_o,
    input logic       hold_o,
    input logic       cap_o,
    input logic [7:0] raw_q
);
    // R3: load mode quiets every action output from the next edge
    p_load_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        load_mode |=> (!halt_o && !loop_dec_o && !hold_o && !cap_o));

    // R11: test mode masks level actions and blocks the capture strobe
    p_test_mask_r11: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> (!halt_o && !loop_dec_o && !hold_o));

    p_test_nocap_r11: assert property (@(posedge clk) disable iff (rst)
        test_mode |=> !cap_o);

    // R1: raw word only visible in test mode
    p_raw_gate_r1: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (raw_q == 8'h00));

    // R7: a capture strobe is always preceded by a mid-period pulse
    p_cap_src_r7: assert property (@(posedge clk) disable iff (rst)
        cap_o |-> $past(mid_stb));

    // R8: hold only rises after a latch strobe or when test mode lifts
    p_hold_entry_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> ($past(lat_stb) || $past(test_mode)));

endmodule

bind vctl_seq vctl_seq_chk u_chk (.*);

// File: tb/vctl_seq_tb.sv
`timescale 1ns/1ps
module vctl_seq_tb;
    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_mode = 1'b1;
    logic          test_mode = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [AW-1:0] vec_addr = '0;
    logic          lat_stb = 1'b0;
    logic          mid_stb = 1'b0;
    logic          wait_in = 1'b0;
    logic          wait_fall = 1'b0;
    logic          loop_exhausted = 1'b0;
    logic          halt_o, loop_dec_o, hold_o, cap_o;
    logic [7:0]    raw_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vctl_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .load_mode(load_mode), .test_mode(test_mode),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .vec_addr(vec_addr), .lat_stb(lat_stb), .mid_stb(mid_stb),
        .wait_in(wait_in), .wait_fall(wait_fall), .loop_exhausted(loop_exhausted),
        .halt_o(halt_o), .loop_dec_o(loop_dec_o), .hold_o(hold_o),
        .cap_o(cap_o), .raw_q(raw_q)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        host_addr = AW'(a); host_wdata = d; host_we = 1'b1;
        tick();
        host_we = 1'b0;
    endtask

    task automatic strobe(input int a);
        vec_addr = AW'(a); lat_stb = 1'b1;
        tick();
        lat_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] w;
        logic       sel;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        // R12: reset state
        chk("R12 outputs", {4'b0, halt_o, loop_dec_o, hold_o, cap_o}, 8'h00);
        chk("R12 raw", raw_q, 8'h00);

        // R1 fill memory in load mode; R3 strobes ignored during load
        for (int a = 0; a < N; a++) wr(a, pat(a));
        vec_addr = AW'(3); lat_stb = 1'b1; mid_stb = 1'b1;
        tick();
        lat_stb = 1'b0; mid_stb = 1'b0;
        tick();
        chk("R3 load quiet", {4'b0, halt_o, loop_dec_o, hold_o, cap_o}, 8'h00);

        // R2 write in drive mode ignored
        load_mode = 1'b0;
        tick();
        wr(5, ~pat(5));

        // R1 / R11 test-mode sweep
        test_mode = 1'b1;
        for (int a = 0; a < N; a++) begin
            vec_addr = AW'(a); lat_stb = 1'b1; mid_stb = 1'b1;
            #1;
            if (a == 5) chk("R2 drive write ignored", raw_q, pat(5));
            else        chk("R1 raw readback", raw_q, pat(a));
            tick();
            lat_stb = 1'b0; mid_stb = 1'b0;
            chk("R11 masked", {5'b0, halt_o, loop_dec_o, hold_o}, 8'h00);
            tick();
            chk("R11 no cap", {7'b0, cap_o}, 8'h00);
        end
        test_mode = 1'b0;
        tick();

        // R4..R8 drive sweep
        for (int a = 0; a < N; a++) begin
            w = pat(a);
            sel = a[1];
            wait_fall = sel; wait_in = sel; loop_exhausted = a[0];
            repeat (4) tick();
            strobe(a);
            chk("R5 halt", {7'b0, halt_o}, {7'b0, w[0] | (w[3] & a[0])});
            chk("R6 loop_dec", {7'b0, loop_dec_o}, {7'b0, w[2] | w[3]});
            chk("R4 hold", {7'b0, hold_o}, {7'b0, w[1]});
            mid_stb = 1'b1;
            tick();
            mid_stb = 1'b0;
            chk("R7 cap", {7'b0, cap_o}, {7'b0, w[4]});
            tick();
            chk("R7 cap width", {7'b0, cap_o}, 8'h00);
            if (w[1]) begin
                wait_in = ~sel;
                tick(); tick();
                chk("R8 hold before release", {7'b0, hold_o}, 8'h01);
                tick();
                chk("R8 release", {7'b0, hold_o}, 8'h00);
            end
        end

        // directed words
        load_mode = 1'b1;
        wr(0, 8'h02); wr(1, 8'h04); wr(2, 8'h09);
        load_mode = 1'b0; loop_exhausted = 1'b0;
        wait_fall = 1'b0; wait_in = 1'b0;
        repeat (4) tick();
        wait_in = 1'b1;            // R9 early rising edge
        repeat (5) tick();
        strobe(0);
        chk("R9 early edge ignored", {7'b0, hold_o}, 8'h01);
        repeat (6) tick();
        chk("R9 still held", {7'b0, hold_o}, 8'h01);
        wait_in = 1'b0;            // R8 wrong polarity
        repeat (5) tick();
        chk("R8 wrong edge", {7'b0, hold_o}, 8'h01);
        strobe(1);                 // R10
        chk("R10 strobe while held", {7'b0, loop_dec_o}, 8'h00);
        wait_in = 1'b1;
        tick(); tick();
        chk("R8 rising pending", {7'b0, hold_o}, 8'h01);
        tick();
        chk("R8 rising release", {7'b0, hold_o}, 8'h00);

        // R11 mask keeps register contents; R5 exhausted path
        test_mode = 1'b1;
        strobe(2);
        chk("R11 halt masked", {7'b0, halt_o}, 8'h00);
        test_mode = 1'b0;
        #1;
        chk("R11 word kept", {6'b0, halt_o, loop_dec_o}, 8'h03);
        tick();

        // R3 load clears register and hold
        load_mode = 1'b1;
        tick();
        chk("R3 cleared", {5'b0, halt_o, loop_dec_o, hold_o}, 8'h00);
        load_mode = 1'b0;
        tick();
        chk("R3 stays clear", {5'b0, halt_o, loop_dec_o, hold_o}, 8'h00);
        strobe(0);
        chk("R4 hold entered", {7'b0, hold_o}, 8'h01);
        load_mode = 1'b1;
        tick();
        chk("R3 hold cleared", {7'b0, hold_o}, 8'h00);
        strobe(1);
        chk("R3 strobe ignored", {7'b0, loop_dec_o}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule